// File: doc/BRIEF.md
# Sized Logic Unit with Status Flags

This block executes one bitwise or sign-inversion operation per clock on a pair of operands whose width is selected per operation as 8, 16 or 32 bits. The supported operations are AND, OR, XOR, TEST (an AND that only reports flags), NOT (one's complement) and NEG (two's complement). Operands arrive with an opcode, a size code and the current flag word. The result, a write-back enable and the updated carry, overflow, zero, sign and parity flags leave through a single register stage.

Each operation has its own flag rule. The bitwise operations force carry and overflow low and derive zero, sign and parity from the result. NOT returns the incoming flags untouched. NEG derives carry and overflow from the operand. TEST updates the flags but withholds write-back, so the destination keeps its value. A surrounding datapath feeds the flag word back in and uses the write-back enable to decide whether the destination register is updated.

Top module: `lgu_unit`

## Requirements
- R1: The opcode encodes 0=AND, 1=OR, 2=XOR, 3=TEST, 4=NOT, 5=NEG. The size code encodes 0=8 bits, 1=16 bits, and 2 or 3=32 bits. Operand bits above the selected size are ignored, and result bits above it are driven to zero. The flag word places carry at bit 0, parity at bit 1, zero at bit 2, sign at bit 3 and overflow at bit 4.
- R2: AND, OR and XOR return the bitwise combination of destination and source, assert write-back, and clear carry and overflow.
- R3: TEST returns the AND of the operands on the result port, keeps write-back low, clears carry and overflow, and sets zero, sign and parity from that AND.
- R4: NOT returns the one's complement of the destination, asserts write-back, and passes all five incoming flags to the output unchanged.
- R5: NEG returns the two's complement of the destination and asserts write-back. Carry is 1 unless the operand is zero. Overflow is 1 only when the operand is the most negative value of the selected size.
- R6: For every operation except NOT and the reserved codes, zero is 1 exactly when the size-limited result is all zeros. In particular, XOR of an operand with itself sets it.
- R7: For the same operations, sign equals the most significant bit of the result at the selected size.
- R8: For the same operations, parity is 1 when the low byte of the result holds an even number of ones.
- R9: The outputs reflect the inputs sampled at a rising edge from that edge until the next one. out_valid equals in_valid of the previous cycle.
- R10: When in_valid is low, or the opcode is 6 or 7, write-back is 0, the result is 0, and the flags equal the incoming flags.
- R11: A synchronous active-high reset clears out_valid, result, write-back and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select |
| size_sel | input | 2 | Operand size select |
| dst_opnd | input | 32 | Destination operand |
| src_opnd | input | 32 | Source operand |
| flags_in | input | 5 | Current flag word |
| out_valid | output | 1 | Registered operation present |
| result | output | 32 | Registered size-limited result |
| wb_en | output | 1 | Registered write-back enable |
| flags_out | output | 5 | Registered updated flag word |

## Verification
Two decisions are made in the same cycle: whether the flags are rewritten and whether the result is written back. TEST and NOT split these decisions in opposite directions, and NEG rewrites carry and overflow from the operand instead of clearing them. The stimulus streams all eight opcodes back to back at every size with random operands and random incoming flags. Biased cases are mixed in: zero operands, lone sign bits and identical XOR operands. A behavioural model checks result, write-back and every flag on every cycle, so a flag path that leaks between neighbouring operations or sizes shows up as a mismatch.

// File: rtl/lgu_pkg.sv
package lgu_pkg;

    localparam int LGU_DW  = 32;
    localparam int LGU_NSZ = 3;
    localparam int LGU_FW  = 5;
    localparam int LGU_SIW = $clog2(LGU_NSZ);

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_TEST = 3'd3,
        OP_NOT  = 3'd4,
        OP_NEG  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } lgu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE      = 2'd0,
        SZ_WORD      = 2'd1,
        SZ_DWORD     = 2'd2,
        SZ_DWORD_ALT = 2'd3
    } lgu_size_e;

    typedef enum logic [1:0] {
        FC_LOGIC = 2'd0,
        FC_NEG   = 2'd1,
        FC_KEEP  = 2'd2
    } lgu_fcls_e;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic par;
        logic cry;
    } lgu_flags_t;

    typedef struct packed {
        logic              vld;
        logic [LGU_DW-1:0] res;
        logic              wb;
        lgu_flags_t        fl;
    } lgu_rsp_t;

    function automatic logic [LGU_SIW-1:0] size_index(lgu_size_e s);
        logic [LGU_SIW-1:0] idx;
        unique case (s)
            SZ_BYTE: idx = LGU_SIW'(0);
            SZ_WORD: idx = LGU_SIW'(1);
            default: idx = LGU_SIW'(2);
        endcase
        return idx;
    endfunction

    function automatic logic even_ones8(logic [7:0] b);
        return ~^b;
    endfunction

endpackage

// File: rtl/lgu_opnd_mask.sv
module lgu_opnd_mask
    import lgu_pkg::*;
(
    input  lgu_size_e         sz,
    input  logic [LGU_DW-1:0] dst,
    input  logic [LGU_DW-1:0] src,
    output logic [LGU_DW-1:0] dst_m,
    output logic [LGU_DW-1:0] src_m,
    output logic [LGU_DW-1:0] mask,
    output logic [LGU_DW-1:0] top_bit
);

    logic [LGU_DW-1:0] mask_tab [LGU_NSZ];

    for (genvar g = 0; g < LGU_NSZ; g++) begin : g_size
        localparam int SW = 8 << g;
        if (SW < LGU_DW) begin : g_part
            assign mask_tab[g] = {{(LGU_DW-SW){1'b0}}, {SW{1'b1}}};
        end else begin : g_full
            assign mask_tab[g] = {LGU_DW{1'b1}};
        end
    end

    always_comb begin
        mask    = mask_tab[size_index(sz)];
        top_bit = mask & ~(mask >> 1);
        dst_m   = dst & mask;
        src_m   = src & mask;
    end

endmodule

// File: rtl/lgu_op_core.sv
module lgu_op_core
    import lgu_pkg::*;
(
    input  lgu_op_e           op,
    input  logic [LGU_DW-1:0] dst_m,
    input  logic [LGU_DW-1:0] src_m,
    input  logic [LGU_DW-1:0] mask,
    input  logic [LGU_DW-1:0] top_bit,
    output logic [LGU_DW-1:0] res,
    output logic              wb,
    output lgu_fcls_e         fcls,
    output logic              neg_cry,
    output logic              neg_ovf
);

    logic [LGU_DW-1:0] neg_val;

    always_comb begin
        neg_val = (~dst_m + LGU_DW'(1)) & mask;
        neg_cry = |dst_m;
        neg_ovf = (dst_m == top_bit);
    end

    always_comb begin
        res  = '0;
        wb   = 1'b0;
        fcls = FC_KEEP;
        unique case (op)
            OP_AND: begin
                res  = dst_m & src_m;
                wb   = 1'b1;
                fcls = FC_LOGIC;
            end
            OP_OR: begin
                res  = dst_m | src_m;
                wb   = 1'b1;
                fcls = FC_LOGIC;
            end
            OP_XOR: begin
                res  = dst_m ^ src_m;
                wb   = 1'b1;
                fcls = FC_LOGIC;
            end
            OP_TEST: begin
                res  = dst_m & src_m;
                wb   = 1'b0;
                fcls = FC_LOGIC;
            end
            OP_NOT: begin
                res  = ~dst_m & mask;
                wb   = 1'b1;
                fcls = FC_KEEP;
            end
            OP_NEG: begin
                res  = neg_val;
                wb   = 1'b1;
                fcls = FC_NEG;
            end
            default: begin
                res  = '0;
                wb   = 1'b0;
                fcls = FC_KEEP;
            end
        endcase
    end

endmodule

// File: rtl/lgu_flag_gen.sv
module lgu_flag_gen
    import lgu_pkg::*;
(
    input  logic [LGU_DW-1:0] res,
    input  lgu_size_e         sz,
    input  lgu_fcls_e         fcls,
    input  logic              neg_cry,
    input  logic              neg_ovf,
    input  lgu_flags_t        fl_in,
    output lgu_flags_t        fl_out
);

    logic [LGU_NSZ-1:0] zero_tab;
    logic [LGU_NSZ-1:0] sign_tab;

    for (genvar g = 0; g < LGU_NSZ; g++) begin : g_size
        localparam int SW = 8 << g;
        assign zero_tab[g] = ~|res[SW-1:0];
        assign sign_tab[g] = res[SW-1];
    end

    logic zro_w, sgn_w, par_w;

    always_comb begin
        zro_w = zero_tab[size_index(sz)];
        sgn_w = sign_tab[size_index(sz)];
        par_w = even_ones8(res[7:0]);
    end

    always_comb begin
        fl_out = fl_in;
        unique case (fcls)
            FC_LOGIC: begin
                fl_out.cry = 1'b0;
                fl_out.ovf = 1'b0;
                fl_out.zro = zro_w;
                fl_out.sgn = sgn_w;
                fl_out.par = par_w;
            end
            FC_NEG: begin
                fl_out.cry = neg_cry;
                fl_out.ovf = neg_ovf;
                fl_out.zro = zro_w;
                fl_out.sgn = sgn_w;
                fl_out.par = par_w;
            end
            default: fl_out = fl_in;
        endcase
    end

endmodule

// File: rtl/lgu_out_reg.sv
module lgu_out_reg
    import lgu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lgu_rsp_t d,
    output lgu_rsp_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/lgu_unit.sv
module lgu_unit
    import lgu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op_code,
    input  logic [1:0]        size_sel,
    input  logic [LGU_DW-1:0] dst_opnd,
    input  logic [LGU_DW-1:0] src_opnd,
    input  logic [LGU_FW-1:0] flags_in,
    output logic              out_valid,
    output logic [LGU_DW-1:0] result,
    output logic              wb_en,
    output logic [LGU_FW-1:0] flags_out
);

    lgu_op_e    op;
    lgu_size_e  sz;
    lgu_flags_t fl_cur;

    assign op     = lgu_op_e'(op_code);
    assign sz     = lgu_size_e'(size_sel);
    assign fl_cur = lgu_flags_t'(flags_in);

    logic [LGU_DW-1:0] dst_m, src_m, mask, top_bit;

    lgu_opnd_mask u_mask (
        .sz      (sz),
        .dst     (dst_opnd),
        .src     (src_opnd),
        .dst_m   (dst_m),
        .src_m   (src_m),
        .mask    (mask),
        .top_bit (top_bit)
    );

    logic [LGU_DW-1:0] core_res;
    logic              core_wb;
    lgu_fcls_e         fcls;
    logic              neg_cry, neg_ovf;

    lgu_op_core u_core (
        .op      (op),
        .dst_m   (dst_m),
        .src_m   (src_m),
        .mask    (mask),
        .top_bit (top_bit),
        .res     (core_res),
        .wb      (core_wb),
        .fcls    (fcls),
        .neg_cry (neg_cry),
        .neg_ovf (neg_ovf)
    );

    lgu_flags_t fl_new;

    lgu_flag_gen u_flags (
        .res     (core_res),
        .sz      (sz),
        .fcls    (fcls),
        .neg_cry (neg_cry),
        .neg_ovf (neg_ovf),
        .fl_in   (fl_cur),
        .fl_out  (fl_new)
    );

    lgu_rsp_t rsp_d, rsp_q;

    always_comb begin
        if (in_valid) begin
            rsp_d.vld = 1'b1;
            rsp_d.res = core_res;
            rsp_d.wb  = core_wb;
            rsp_d.fl  = fl_new;
        end else begin
            rsp_d.vld = 1'b0;
            rsp_d.res = '0;
            rsp_d.wb  = 1'b0;
            rsp_d.fl  = fl_cur;
        end
    end

    lgu_out_reg u_oreg (
        .clk (clk),
        .rst (rst),
        .d   (rsp_d),
        .q   (rsp_q)
    );

    assign out_valid = rsp_q.vld;
    assign result    = rsp_q.res;
    assign wb_en     = rsp_q.wb;
    assign flags_out = rsp_q.fl;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid)); // R9

    AST_LOGIC_CLEARS_CO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(op_code) < 3'd4)) |-> (!flags_out[0] && !flags_out[4])); // R2

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(op_code) == 3'd3)) |-> !wb_en); // R3

    AST_NOT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(op_code) == 3'd4)) |-> (flags_out == $past(flags_in))); // R4

    AST_NEG_CARRY: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(op_code) == 3'd5)) |-> (flags_out[0] == (result != '0))); // R5

    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(op_code) < 3'd6) && ($past(op_code) != 3'd4))
        |-> (flags_out[2] == (result == '0))); // R6

    AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ($past(size_sel) == 2'd0)) |-> (result[LGU_DW-1:8] == '0)); // R1

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!out_valid) |-> (!wb_en && (result == '0))); // R10

endmodule

// File: tb/lgu_unit_test.sv
module lgu_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op_code;
    logic [1:0]  size_sel;
    logic [31:0] dst_opnd, src_opnd;
    logic [4:0]  flags_in;
    logic        out_valid;
    logic [31:0] result;
    logic        wb_en;
    logic [4:0]  flags_out;

    always #2 clk = ~clk;

    lgu_unit uut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op_code   (op_code),
        .size_sel  (size_sel),
        .dst_opnd  (dst_opnd),
        .src_opnd  (src_opnd),
        .flags_in  (flags_in),
        .out_valid (out_valid),
        .result    (result),
        .wb_en     (wb_en),
        .flags_out (flags_out)
    );

    typedef struct packed {
        logic        v;
        logic [2:0]  op;
        logic [1:0]  sz;
        logic [31:0] r;
        logic        wb;
        logic [4:0]  f;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done     = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic exp_t model(input logic v, input logic [2:0] op, input logic [1:0] sz,
                                   input logic [31:0] d0, input logic [31:0] s0,
                                   input logic [4:0] fin);
        exp_t e;
        int n;
        longint m, d, s, r;
        int ones;
        n = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        m = (64'd1 << n) - 1;
        d = longint'(d0) & m;
        s = longint'(s0) & m;
        e.v = v; e.op = op; e.sz = sz; e.wb = 1'b1; e.f = fin;
        case (op)
            3'd0: r = d & s;
            3'd1: r = d | s;
            3'd2: r = d ^ s;
            3'd3: begin r = d & s; e.wb = 1'b0; end
            3'd4: r = ~d & m;
            3'd5: r = (0 - d) & m;
            default: begin r = 0; e.wb = 1'b0; end
        endcase
        if (!v) begin
            r = 0;
            e.wb = 1'b0;
        end
        e.r = r[31:0];
        if (v && op < 3'd6 && op != 3'd4) begin
            ones = 0;
            for (int i = 0; i < 8; i++) ones += int'(r[i]);
            e.f[2] = (r == 0);
            e.f[3] = r[n-1];
            e.f[1] = (ones % 2 == 0);
            if (op == 3'd5) begin
                e.f[0] = (d != 0);
                e.f[4] = (d == (64'd1 << (n - 1)));
            end else begin
                e.f[0] = 1'b0;
                e.f[4] = 1'b0;
            end
        end
        return e;
    endfunction

    function automatic string op_req(input exp_t e);
        if (!e.v || e.op >= 3'd6) return "R10";
        case (e.op)
            3'd3: return "R3";
            3'd4: return "R4";
            3'd5: return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic compare_head();
        exp_t e;
        string t;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = op_req(e);
        chk(out_valid == e.v, "R9", "out_valid", longint'(out_valid), longint'(e.v));
        chk(result == e.r, (e.sz < 2'd2) ? {t, "/R1"} : t, "result", longint'(result), longint'(e.r));
        chk(wb_en == e.wb, t, "wb_en", longint'(wb_en), longint'(e.wb));
        if (e.v && e.op < 3'd6 && e.op != 3'd4) begin
            chk(flags_out[2] == e.f[2], "R6", "zero", longint'(flags_out[2]), longint'(e.f[2]));
            chk(flags_out[3] == e.f[3], "R7", "sign", longint'(flags_out[3]), longint'(e.f[3]));
            chk(flags_out[1] == e.f[1], "R8", "parity", longint'(flags_out[1]), longint'(e.f[1]));
            chk(flags_out[0] == e.f[0], t, "carry", longint'(flags_out[0]), longint'(e.f[0]));
            chk(flags_out[4] == e.f[4], t, "overflow", longint'(flags_out[4]), longint'(e.f[4]));
        end else begin
            chk(flags_out == e.f, t, "flags kept", longint'(flags_out), longint'(e.f));
        end
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic [1:0] sz,
                        input logic [31:0] d, input logic [31:0] s, input logic [4:0] f);
        @(negedge clk);
        compare_head();
        in_valid = v; op_code = op; size_sel = sz;
        dst_opnd = d; src_opnd = s; flags_in = f;
        exp_q.push_back(model(v, op, sz, d, s, f));
    endtask

    function automatic logic [31:0] pick_opnd();
        unique case ($urandom_range(0, 5))
            0: return 32'h0;
            1: return 32'h0000_0080;
            2: return 32'h0000_8000;
            3: return 32'h8000_0000;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_code = '0; size_sel = '0;
        dst_opnd = '0; src_opnd = '0; flags_in = 5'h1F;
        repeat (3) @(negedge clk);
        // R11: reset state while reset is held
        chk(out_valid == 1'b0, "R11", "out_valid", longint'(out_valid), 0);
        chk(result == 32'h0, "R11", "result", longint'(result), 0);
        chk(wb_en == 1'b0, "R11", "wb_en", longint'(wb_en), 0);
        chk(flags_out == 5'h0, "R11", "flags", longint'(flags_out), 0);
        rst = 1'b0;

        step(1, 3'd2, 2'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 5'h00); // R6 xor self
        step(1, 3'd2, 2'd0, 32'h1234_5655, 32'h0000_0055, 5'h1F); // R1 R6 upper bits ignored
        step(1, 3'd0, 2'd1, 32'hFFFF_F0F0, 32'h0000_8F0F, 5'h11); // R2 R7
        step(1, 3'd1, 2'd0, 32'h0000_0003, 32'h0000_0000, 5'h11); // R8 parity even
        step(1, 3'd3, 2'd0, 32'h0000_0081, 32'h0000_0080, 5'h00); // R3
        step(1, 3'd3, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 5'h1F); // R3
        step(1, 3'd4, 2'd1, 32'h0000_00FF, 32'h0, 5'h15);         // R4
        step(1, 3'd4, 2'd2, 32'h0, 32'h0, 5'h0A);                 // R4
        step(1, 3'd5, 2'd0, 32'h0000_0080, 32'h0, 5'h00);         // R5 most negative byte
        step(1, 3'd5, 2'd1, 32'h0001_0000, 32'h0, 5'h1F);         // R5 zero at word size
        step(1, 3'd5, 2'd3, 32'h8000_0000, 32'h0, 5'h00);         // R5 most negative dword
        step(1, 3'd5, 2'd1, 32'h0000_0001, 32'h0, 5'h00);         // R5 R7
        step(1, 3'd6, 2'd2, 32'h1234_5678, 32'h1, 5'h0C);         // R10 reserved
        step(1, 3'd7, 2'd0, 32'h1, 32'h1, 5'h13);                 // R10 reserved
        step(0, 3'd0, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'h07); // R10 idle

        for (int k = 0; k < 4000; k++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = pick_opnd();
            b = ($urandom_range(0, 7) == 0) ? a : pick_opnd();
            step(($urandom_range(0, 9) != 0), 3'($urandom_range(0, 7)),
                 2'($urandom_range(0, 3)), a, b, 5'($urandom_range(0, 31)));
        end
        step(0, 3'd0, 2'd0, 32'h0, 32'h0, 5'h00);
        @(negedge clk);
        compare_head();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R9 watchdog: actual hung expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule